// File: doc/BRIEF.md
# Range-Qualified ECC Write Checker

This block sits on the write path of a memory controller, between a bus initiator and a 72-bit memory array (64 data bits plus one check byte per word). Every write beat is passed to the array one cycle later. When protection is on for the beat, the block also generates an 8-bit single-error-correct, double-error-detect check byte for the 64-bit word.

Protection is decided once per burst, on its first beat. It applies only while the global enable is set and the burst's start word falls inside one of two programmable, individually validated address windows. A protected burst must start on an 8-byte boundary and must write whole 64-bit words on every beat. A burst that breaks either rule still commits its data bytes. The block does not rebuild the check byte of a partly written word; instead it leaves that check byte untouched and raises a sticky write-ECC error. The error records the first offending byte address and drives an interrupt line.

A small word-addressed register port holds the enable, the window bounds, the error status and the captured address.

Top module: `ecc_wr_checker`

## Requirements
- R1: Each beat accepted with `wr_valid` appears on the array port on the next clock edge: `mem_we` high, `mem_addr` equal to the beat's 64-bit word address (start word on the first beat, then one more per beat), and `mem_data[63:0]` equal to the beat data. With no input beat, `mem_we` is low on the next cycle.
- R2: After reset the enable is 0. While a burst is unprotected, `mem_data[71:64]` is 0 and `mem_be[8]` is 1 on every beat, whatever its byte enables.
- R3: A burst is protected when the enable is set and its first-beat byte address, with the low 3 bits dropped, lies between the low and high bound of a window whose valid bit is set, both bounds inclusive. A protected full beat writes the check byte with `mem_be[8]` = 1.
- R4: A protected burst whose start address has nonzero bits [2:0] is a violation; the captured address is that start byte address.
- R5: A beat of a protected burst with any byte enable low is a violation; the captured address is that beat's word address times 8.
- R6: A violation sets the status bit (register 1, bit 0) at the same edge as the beat's array write. The bit stays set until a register write of 1 to that bit, and a violation in the same cycle wins. `irq` equals the status bit.
- R7: The captured address (register 2) is loaded only when a violation occurs while the status is clear (or being cleared). Otherwise it holds.
- R8: `mem_be[7:0]` always equals the beat's byte enables, so a violating beat still writes its bytes. On a protected beat with partial byte enables, `mem_be[8]` is 0.
- R9: Register map: 0 = control (bit 0 enable, bit 1 window A valid, bit 2 window B valid); 3/4 = window A low/high; 5/6 = window B low/high, address bits [31:3] kept and [2:0] reading 0; 7 reads 0. All read back what was written.
- R10: The check byte is an extended Hamming code. The 64 data bits go, in ascending order, to positions 1..71 of the codeword that are not powers of two. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wr_valid | input | 1 | Write beat present |
| wr_first | input | 1 | Beat is the first of a burst |
| wr_addr | input | AW | Burst start byte address (used on first beat) |
| wr_data | input | 64 | Beat data |
| wr_be | input | 8 | Beat byte enables |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW-3 | Array word address |
| mem_data | output | 72 | Check byte [71:64] and data [63:0] |
| mem_be | output | 9 | Check-lane enable [8] and data byte enables [7:0] |
| irq | output | 1 | Write ECC error interrupt |

## Verification
The assertions check, on every cycle, the one-cycle beat forwarding, the zero check lane while disabled, the rule that a violation sets the status, status stickiness, the captured address holding still, and the ban on a generated check byte landing with a partial word. Only the bench scenarios show the code values themselves, the inclusive window bounds and the effect of window valid bits. They also show which address is captured for a misaligned start versus a partial beat, and the register readback. These scenarios compare against a model that builds the code by summing bit positions.

// File: rtl/ecc_wr_pkg.sv
package ecc_wr_pkg;

    localparam int DW    = 64;
    localparam int CW    = 8;
    localparam int BW    = DW / 8;
    localparam int NWIN  = 2;
    localparam int CWLEN = DW + CW;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_EADDR = 3'd2,
        REG_A_LO  = 3'd3,
        REG_A_HI  = 3'd4,
        REG_B_LO  = 3'd5,
        REG_B_HI  = 3'd6,
        REG_RSVD  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NWIN-1:0] win_vld;
        logic            en;
    } ctrl_t;

    // Extended Hamming check byte over one 64-bit word (R10)
    function automatic logic [CW-1:0] secded8(input logic [DW-1:0] d);
        logic [CWLEN-1:0] cw;
        logic [CW-1:0]    c;
        int               k;
        cw = '0;
        c  = '0;
        k  = 0;
        for (int p = 1; p < CWLEN; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < CW - 1; i++) begin
            for (int p = 1; p < CWLEN; p++) begin
                if (p[i]) c[i] = c[i] ^ cw[p];
            end
        end
        c[CW-1] = (^d) ^ (^c[CW-2:0]);
        return c;
    endfunction

endpackage

// File: rtl/ecc_wr_range.sv
module ecc_wr_range #(
    parameter int WAW = 29,
    parameter int NW  = 2
) (
    input  logic [NW-1:0][WAW-1:0] win_lo,
    input  logic [NW-1:0][WAW-1:0] win_hi,
    input  logic [NW-1:0]          win_vld,
    input  logic [WAW-1:0]         word,
    output logic                   hit
);
    logic [NW-1:0] hit_each;

    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_win
            assign hit_each[g] = win_vld[g] && (word >= win_lo[g]) && (word <= win_hi[g]);
        end
    endgenerate

    assign hit = |hit_each;
endmodule

// File: rtl/ecc_wr_regs.sv
module ecc_wr_regs
    import ecc_wr_pkg::*;
#(
    parameter int  AW  = 32,
    localparam int WAW = AW - 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [2:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic                     viol,
    input  logic [AW-1:0]            viol_addr,
    output ctrl_t                    ctrl,
    output logic [NWIN-1:0][WAW-1:0] win_lo,
    output logic [NWIN-1:0][WAW-1:0] win_hi,
    output logic                     status,
    output logic [AW-1:0]            err_addr
);
    reg_sel_e sel;
    logic     clr;

    assign sel = reg_sel_e'(reg_addr);
    assign clr = reg_we && (sel == REG_STAT) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            win_lo   <= '0;
            win_hi   <= '0;
            status   <= 1'b0;
            err_addr <= '0;
        end else begin
            if (reg_we) begin
                case (sel)
                    REG_CTRL: begin
                        ctrl.en      <= reg_wdata[0];
                        ctrl.win_vld <= reg_wdata[NWIN:1];
                    end
                    REG_A_LO: win_lo[0] <= reg_wdata[AW-1:3];
                    REG_A_HI: win_hi[0] <= reg_wdata[AW-1:3];
                    REG_B_LO: win_lo[1] <= reg_wdata[AW-1:3];
                    REG_B_HI: win_hi[1] <= reg_wdata[AW-1:3];
                    default: ;
                endcase
            end
            if (viol) begin
                status <= 1'b1;
            end else if (clr) begin
                status <= 1'b0;
            end
            if (viol && (!status || clr)) begin
                err_addr <= viol_addr;
            end
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL:  reg_rdata = 32'({ctrl.win_vld, ctrl.en});
            REG_STAT:  reg_rdata = {31'd0, status};
            REG_EADDR: reg_rdata = 32'(err_addr);
            REG_A_LO:  reg_rdata = 32'({win_lo[0], 3'b000});
            REG_A_HI:  reg_rdata = 32'({win_hi[0], 3'b000});
            REG_B_LO:  reg_rdata = 32'({win_lo[1], 3'b000});
            REG_B_HI:  reg_rdata = 32'({win_hi[1], 3'b000});
            default:   reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/ecc_wr_path.sv
module ecc_wr_path
    import ecc_wr_pkg::*;
#(
    parameter int  AW  = 32,
    localparam int WAW = AW - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [BW-1:0]    wr_be,
    input  logic             ecc_en,
    input  logic             win_hit,
    output logic             mem_we,
    output logic [WAW-1:0]   mem_addr,
    output logic [CWLEN-1:0] mem_data,
    output logic [BW:0]      mem_be,
    output logic             viol,
    output logic [AW-1:0]    viol_addr
);
    logic [WAW-1:0] cur_word_q;
    logic           cur_prot_q;
    logic [WAW-1:0] beat_word;
    logic           prot;
    logic           misalign;
    logic           partial;

    always_comb begin
        beat_word = wr_first ? wr_addr[AW-1:3] : cur_word_q;
        prot      = wr_first ? (ecc_en && win_hit) : cur_prot_q;
        misalign  = wr_first && (wr_addr[2:0] != 3'b000);
        partial   = (wr_be != '1);
        viol      = wr_valid && prot && (misalign || partial);
        viol_addr = misalign ? wr_addr : {beat_word, 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_word_q <= '0;
            cur_prot_q <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_data   <= '0;
            mem_be     <= '0;
        end else begin
            mem_we <= wr_valid;
            if (wr_valid) begin
                cur_word_q <= beat_word + WAW'(1);
                cur_prot_q <= prot;
                mem_addr   <= beat_word;
                mem_data   <= {(prot ? secded8(wr_data) : CW'(0)), wr_data};
                mem_be     <= {(prot ? !partial : 1'b1), wr_be};
            end
        end
    end
endmodule

// File: rtl/ecc_wr_checker.sv
module ecc_wr_checker
    import ecc_wr_pkg::*;
#(
    parameter int  AW  = 32,
    localparam int WAW = AW - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [BW-1:0]    wr_be,
    output logic             mem_we,
    output logic [WAW-1:0]   mem_addr,
    output logic [CWLEN-1:0] mem_data,
    output logic [BW:0]      mem_be,
    output logic             irq
);
    ctrl_t                    ctrl;
    logic [NWIN-1:0][WAW-1:0] win_lo;
    logic [NWIN-1:0][WAW-1:0] win_hi;
    logic                     status;
    logic [AW-1:0]            err_addr;
    logic                     win_hit;
    logic                     viol;
    logic [AW-1:0]            viol_addr;
    logic                     ecc_en;

    assign ecc_en = ctrl.en;
    assign irq    = status;

    ecc_wr_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .viol      (viol),
        .viol_addr (viol_addr),
        .ctrl      (ctrl),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .status    (status),
        .err_addr  (err_addr)
    );

    ecc_wr_range #(.WAW(WAW), .NW(NWIN)) u_range (
        .win_lo  (win_lo),
        .win_hi  (win_hi),
        .win_vld (ctrl.win_vld),
        .word    (wr_addr[AW-1:3]),
        .hit     (win_hit)
    );

    ecc_wr_path #(.AW(AW)) u_path (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_first  (wr_first),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .ecc_en    (ecc_en),
        .win_hit   (win_hit),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_be    (mem_be),
        .viol      (viol),
        .viol_addr (viol_addr)
    );
endmodule

// File: rtl/ecc_wr_checker_sva.sv
module ecc_wr_checker_sva #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          wr_valid,
    input logic          mem_we,
    input logic [71:0]   mem_data,
    input logic [8:0]    mem_be,
    input logic          irq,
    input logic          ecc_en,
    input logic          viol,
    input logic [AW-1:0] err_addr
);
    logic clr;
    assign clr = reg_we && (reg_addr == 3'd1) && reg_wdata[0];

    AST_BEAT_FORWARD: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> mem_we);  // R1
    AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !mem_we);  // R1
    AST_OFF_ZERO_LANE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !ecc_en) |=> (mem_be[8] && (mem_data[71:64] == 8'h00)));  // R2
    AST_VIOL_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        viol |=> irq);  // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);  // R6
    AST_EADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> $stable(err_addr));  // R7
    AST_PARTIAL_NO_CODE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && (mem_be[7:0] != 8'hFF)) |-> (!mem_be[8] || (mem_data[71:64] == 8'h00)));  // R8
endmodule

bind ecc_wr_checker ecc_wr_checker_sva #(.AW(AW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wr_valid  (wr_valid),
    .mem_we    (mem_we),
    .mem_data  (mem_data),
    .mem_be    (mem_be),
    .irq       (irq),
    .ecc_en    (ecc_en),
    .viol      (viol),
    .err_addr  (err_addr)
);

// File: tb/ecc_wr_checker_tb.sv
module ecc_wr_checker_tb;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        wr_valid;
    logic        wr_first;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;
    logic        mem_we;
    logic [28:0] mem_addr;
    logic [71:0] mem_data;
    logic [8:0]  mem_be;
    logic        irq;

    int total = 0;
    int bad   = 0;

    bit          m_en, m_va, m_vb, m_stat;
    logic [31:0] m_alo, m_ahi, m_blo, m_bhi, m_eaddr;
    bit          b_prot;
    logic [28:0] b_word;

    always #2 clk = ~clk;

    ecc_wr_checker #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
        .wr_first(wr_first), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_code(input logic [63:0] d);
        logic [6:0] syn;
        int         pos;
        syn = '0;
        pos = 1;
        for (int j = 0; j < 64; j++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[j]) syn = syn ^ 7'(pos);
        end
        return {(^d) ^ (^syn), syn};
    endfunction

    function automatic bit in_win(input logic [31:0] a);
        logic [31:0] w;
        w = a & 32'hFFFF_FFF8;
        return (m_va && w >= m_alo && w <= m_ahi) || (m_vb && w >= m_blo && w <= m_bhi);
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        case (a)
            3'd0: begin m_en = d[0]; m_va = d[1]; m_vb = d[2]; end
            3'd1: if (d[0]) m_stat = 1'b0;
            3'd3: m_alo = d & 32'hFFFF_FFF8;
            3'd4: m_ahi = d & 32'hFFFF_FFF8;
            3'd5: m_blo = d & 32'hFFFF_FFF8;
            3'd6: m_bhi = d & 32'hFFFF_FFF8;
            default: ;
        endcase
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send_beat(input bit first, input logic [31:0] addr, input logic [63:0] d,
                             input logic [7:0] be, input string tag);
        bit          misal, part, v;
        logic [71:0] exp_data;
        logic [8:0]  exp_be;
        wr_valid = 1'b1; wr_first = first; wr_addr = addr; wr_data = d; wr_be = be;
        if (first) begin
            b_word = addr[31:3];
            b_prot = m_en && in_win(addr);
        end
        misal = first && (addr[2:0] != 3'b000);
        part  = (be != 8'hFF);
        v     = b_prot && (misal || part);
        if (v && !m_stat) begin
            m_stat  = 1'b1;
            m_eaddr = misal ? addr : {b_word, 3'b000};
        end
        exp_data = {(b_prot ? ref_code(d) : 8'h00), d};
        exp_be   = {(b_prot ? !part : 1'b1), be};
        @(posedge clk); #1;
        chk(mem_we === 1'b1, "R1", "mem_we", 72'(mem_we), 72'd1);
        chk(mem_addr === b_word, "R1", "mem_addr", 72'(mem_addr), 72'(b_word));
        chk(mem_data === exp_data, tag, "mem_data", mem_data, exp_data);
        chk(mem_be === exp_be, "R8", "mem_be", 72'(mem_be), 72'(exp_be));
        chk(irq === m_stat, "R6", "irq", 72'(irq), 72'(m_stat));
        b_word = b_word + 29'd1;
        @(negedge clk);
        wr_valid = 1'b0; wr_first = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd4242));
        rst = 1'b1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        wr_valid = 0; wr_first = 0; wr_addr = 0; wr_data = 0; wr_be = 0;
        m_en = 0; m_va = 0; m_vb = 0; m_stat = 0;
        m_alo = 0; m_ahi = 0; m_blo = 0; m_bhi = 0; m_eaddr = 0;
        b_prot = 0; b_word = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state (R2, R9)
        reg_read(3'd0, rv); chk(rv == 0, "R2", "ctrl after reset", 72'(rv), 0);
        reg_read(3'd1, rv); chk(rv == 0, "R6", "status after reset", 72'(rv), 0);
        reg_read(3'd2, rv); chk(rv == 0, "R7", "eaddr after reset", 72'(rv), 0);
        chk(irq === 1'b0 && mem_we === 1'b0, "R2", "irq/mem_we after reset", 72'({irq, mem_we}), 0);
        @(negedge clk);

        // Window registers and readback (R9)
        reg_write(3'd3, 32'h0000_1003);
        reg_write(3'd4, 32'h0000_10F8);
        reg_write(3'd5, 32'h0000_8000);
        reg_write(3'd6, 32'h0000_8FF8);
        reg_write(3'd0, 32'h6);
        reg_read(3'd3, rv); chk(rv == 32'h1000, "R9", "A low readback", 72'(rv), 72'h1000);
        reg_read(3'd6, rv); chk(rv == 32'h8FF8, "R9", "B high readback", 72'(rv), 72'h8FF8);
        reg_read(3'd0, rv); chk(rv == 32'h6, "R9", "ctrl readback", 72'(rv), 72'h6);
        reg_read(3'd7, rv); chk(rv == 0, "R9", "reserved reads 0", 72'(rv), 0);
        @(negedge clk);

        // Disabled: even a partial beat in-window is unchecked (R2)
        send_beat(1, 32'h1000, 64'h0123_4567_89AB_CDEF, 8'h0F, "R2");
        chk(irq === 1'b0, "R2", "no error while disabled", 72'(irq), 0);

        // Enabled, protected full burst (R10, R3)
        reg_write(3'd0, 32'h7);
        send_beat(1, 32'h1000, 64'hDEAD_BEEF_0000_0001, 8'hFF, "R10");
        send_beat(0, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R10");
        chk(mem_data[71:64] === ref_code(64'hFFFF_FFFF_FFFF_FFFF) && mem_be[8] === 1'b1,
            "R3", "protected check lane written", 72'(mem_data[71:64]), 72'(ref_code(64'hFFFF_FFFF_FFFF_FFFF)));
        // Inclusive upper bound and just outside (R3)
        send_beat(1, 32'h10F8, 64'h1, 8'hFF, "R3");
        send_beat(1, 32'h1100, 64'h2, 8'h3C, "R3");
        chk(irq === 1'b0, "R3", "outside window unchecked", 72'(irq), 0);
        // Window B invalid (R3)
        reg_write(3'd0, 32'h3);
        send_beat(1, 32'h8000, 64'h3, 8'h01, "R3");
        chk(irq === 1'b0, "R3", "invalid window unchecked", 72'(irq), 0);
        reg_write(3'd0, 32'h7);

        // Misaligned start (R4)
        send_beat(1, 32'h1004, 64'h4444, 8'hF0, "R4");
        reg_read(3'd2, rv); chk(rv == 32'h1004, "R4", "captured misaligned addr", 72'(rv), 72'h1004);
        reg_read(3'd1, rv); chk(rv == 1, "R6", "status set", 72'(rv), 1);
        @(negedge clk);
        // Second violation holds captured address (R7)
        send_beat(1, 32'h1010, 64'h5, 8'hFF, "R1");
        send_beat(0, 32'h0, 64'h6, 8'h7F, "R8");
        reg_read(3'd2, rv); chk(rv == 32'h1004, "R7", "eaddr held", 72'(rv), 72'h1004);
        @(negedge clk);
        // Write 0 does not clear; write 1 clears (R6)
        reg_write(3'd1, 32'h0);
        chk(irq === 1'b1, "R6", "write 0 keeps status", 72'(irq), 1);
        reg_write(3'd1, 32'h1);
        chk(irq === 1'b0, "R6", "W1C clears", 72'(irq), 0);

        // Partial beat later in burst (R5)
        send_beat(1, 32'h8008, 64'h7, 8'hFF, "R1");
        send_beat(0, 32'h0, 64'h8, 8'h0F, "R5");
        reg_read(3'd2, rv); chk(rv == 32'h8010, "R5", "captured partial-beat addr", 72'(rv), 72'h8010);
        @(negedge clk);
        reg_write(3'd1, 32'h1);

        // Idle cycle: no array write (R1)
        @(posedge clk); #1;
        chk(mem_we === 1'b0, "R1", "idle no write", 72'(mem_we), 0);
        @(negedge clk);

        // Constrained random bursts
        for (int it = 0; it < 120; it++) begin
            logic [31:0] base, addr;
            int          n;
            case ($urandom % 6)
                0: base = 32'h0FE0;
                1: base = 32'h10D0;
                2: base = 32'h7FE0;
                3: base = 32'h8FD0;
                4: base = 32'h4000;
                default: base = 32'h1040;
            endcase
            addr = base + 32'(($urandom % 8) * 8);
            if ($urandom % 5 == 0) addr = addr + 32'($urandom % 8);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) begin
                logic [7:0] be;
                be = ($urandom % 6 == 0) ? 8'($urandom) : 8'hFF;
                send_beat(k == 0, addr, {$urandom, $urandom}, be, "R10");
            end
            if (it % 15 == 14) begin
                if (m_stat) begin
                    reg_read(3'd2, rv);
                    chk(rv == m_eaddr, "R7", "random eaddr", 72'(rv), 72'(m_eaddr));
                    @(negedge clk);
                    reg_write(3'd1, 32'h1);
                end
                reg_write(3'd0, ($urandom % 4 == 0) ? 32'h0 : 32'h7);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule